// File: doc/BRIEF.md
# Stack Pop Multiple Load Sequencer

This block executes a 16-bit "pop multiple registers" instruction. On a start strobe it decodes the instruction's register mask, checks that it is legal and that the stack pointer is word aligned, and then issues one 32-bit word read per selected register. The reads begin at the stack pointer and step up by 4. Each returned word goes either to a register-file write strobe or, for the program-counter slot, to a branch-target output. When the last word has been handled, the block pulses `done` and presents the updated stack pointer.

The memory side is a plain request/valid read port. `mem_req` stays high and `mem_addr` stays stable until `mem_valid` returns, so a slow memory holds the sequencer back; it never has more than one read outstanding. Memory returns at most one `mem_valid` per request. Register writes, branch outputs and `done` are single-cycle pulses with no back-pressure, because a register file always accepts a write.

An illegal instruction takes priority over a misaligned stack pointer. Either case ends after one cycle with no memory traffic.

Top module: `stack_pop_sequencer`

## Requirements
- R1: The instruction decodes only when bits [15:9] equal 1011110. Bits [7:0] select registers 0 to 7 (bit n selects register n) and bit 8 selects the program counter, register 15. A non-matching opcode raises `illegal` with `done` and performs no loads. Register-file writes only ever target indices 0 to 7.
- R2: Selected general registers are loaded in ascending index order. The k-th load (k from 0) reads address `sp_in + 4*k` and is reported as a one-cycle `rf_we` with `rf_idx` and `rf_data` equal to the returned word, one cycle after `mem_valid`.
- R3: When bit 8 is set, the program-counter word is loaded last, from the highest address. It produces a one-cycle `branch_valid` in place of a register write. `branch_target` is the word with bit 0 cleared and `isa_sel` equals the word's bit 0.
- R4: `done` pulses for exactly one cycle, in the cycle after the final write or branch pulse. `new_sp` then equals `sp_in` plus 4 times the number of set bits in {bit 8, 7 zero bits, bits [7:0]}, modulo 2^32.
- R5: An instruction with bits [8:0] all zero raises `illegal` with `done` in the cycle after start, issues no memory request and returns `new_sp` equal to `sp_in`.
- R6: Bit 8 set while `in_cond_block` is 1 and `last_in_block` is 0 raises `illegal` as in R5. Bit 8 set with `last_in_block` equal to 1 is legal.
- R7: A legal instruction with `sp_in[1:0]` not 00 raises `align_fault` with `done` in the cycle after start, with no loads and with `new_sp` equal to `sp_in`. Every issued `mem_addr` has its low two bits at 00.
- R8: `mem_req` and `mem_addr` hold steady until `mem_valid`. Memory latency only delays the sequence and never changes its results.
- R9: A `start` pulse while a sequence is running is ignored. The running sequence's writes and `new_sp` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` (ignored while busy) |
| instr | input | 16 | Instruction word |
| in_cond_block | input | 1 | Instruction sits inside a conditional block |
| last_in_block | input | 1 | Instruction is the last of its conditional block |
| sp_in | input | 32 | Stack pointer at start |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read word address |
| mem_rdata | input | 32 | Read data |
| mem_valid | input | 1 | Read data valid |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 4 | Register index written |
| rf_data | output | 32 | Register data written |
| branch_valid | output | 1 | Program counter loaded |
| branch_target | output | 32 | Branch address, bit 0 cleared |
| isa_sel | output | 1 | Bit 0 of the loaded program-counter word |
| done | output | 1 | Sequence finished (one cycle) |
| new_sp | output | 32 | Updated stack pointer, valid with `done` |
| illegal | output | 1 | Illegal instruction, valid with `done` |
| align_fault | output | 1 | Misaligned stack pointer, valid with `done` |

## Verification
Faulting instructions report on the first sample after the start edge. For legal ones, each register write or branch pulse appears one cycle after its `mem_valid`, and `done` follows the last such pulse by exactly one cycle. The bench samples every cycle on the falling edge from the start pulse onward. It compares each write against the next expected index and address-derived data as it arrives, and it checks that the cycle before `done` carried the final write. The memory model is run both with immediate and with delayed read returns, so the same expectations hold under stalls.

// File: rtl/pop_seq_pkg.sv
package pop_seq_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOAD = 2'd1,
    PS_FIN  = 2'd2
  } pop_state_e;

  localparam int unsigned PC_IDX = 15;
endpackage

// File: rtl/pop_decode.sv
module pop_decode #(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned MASK_W  = 16,
  parameter int unsigned GPR_N   = 8
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               in_cond_block,
  input  logic               last_in_block,
  output logic [MASK_W-1:0]  mask,
  output logic               bad
);
  localparam int unsigned OPC_W = INSTR_W - GPR_N - 1;
  localparam logic [OPC_W-1:0] OPC = 7'b1011110;
  localparam int unsigned GAP_W = MASK_W - GPR_N - 1;

  logic opc_hit;
  logic pc_bit;
  logic empty;
  logic pc_misplaced;

  assign opc_hit = instr[INSTR_W-1 -: OPC_W] == OPC;
  assign pc_bit  = instr[GPR_N];
  assign mask    = {pc_bit, {GAP_W{1'b0}}, instr[GPR_N-1:0]};
  assign empty   = mask == '0;
  assign pc_misplaced = pc_bit && in_cond_block && !last_in_block;
  assign bad     = !opc_hit || empty || pc_misplaced;
endmodule

// File: rtl/pop_pick.sv
module pop_pick #(
  parameter int unsigned MASK_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [MASK_W-1:0] mask,
  output logic [IDX_W-1:0]  idx,
  output logic [MASK_W-1:0] rest,
  output logic              final_one
);
  logic [MASK_W-1:0] low_oh;
  logic [IDX_W-1:0]  part [MASK_W];

  assign low_oh = mask & (~mask + 1'b1);

  for (genvar g = 0; g < MASK_W; g++) begin : g_enc
    if (g == 0) begin : g_first
      assign part[g] = '0;
    end else begin : g_next
      assign part[g] = part[g-1] | (low_oh[g] ? IDX_W'(g) : '0);
    end
  end

  assign idx       = part[MASK_W-1];
  assign rest      = mask & ~low_oh;
  assign final_one = rest == '0;
endmodule

// File: rtl/stack_pop_sequencer.sv
module stack_pop_sequencer
  import pop_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned INSTR_W    = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INSTR_W-1:0] instr,
  input  logic              in_cond_block,
  input  logic              last_in_block,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_valid,
  output logic              rf_we,
  output logic [3:0]        rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              branch_valid,
  output logic [ADDR_W-1:0] branch_target,
  output logic              isa_sel,
  output logic              done,
  output logic [ADDR_W-1:0] new_sp,
  output logic              illegal,
  output logic              align_fault
);
  localparam int unsigned MASK_W     = 16;
  localparam int unsigned IDX_W      = $clog2(MASK_W);
  localparam int unsigned GPR_N      = 8;
  localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

  pop_state_e        state_q;
  logic [MASK_W-1:0] mask_q;
  logic [ADDR_W-1:0] addr_q;

  logic [MASK_W-1:0] dec_mask;
  logic              dec_bad;
  logic [IDX_W-1:0]  cur_idx;
  logic [MASK_W-1:0] rest_mask;
  logic              cur_final;
  logic              sp_misaligned;

  pop_decode #(.INSTR_W(INSTR_W), .MASK_W(MASK_W), .GPR_N(GPR_N)) u_decode (
    .instr         (instr),
    .in_cond_block (in_cond_block),
    .last_in_block (last_in_block),
    .mask          (dec_mask),
    .bad           (dec_bad)
  );

  pop_pick #(.MASK_W(MASK_W), .IDX_W(IDX_W)) u_pick (
    .mask      (mask_q),
    .idx       (cur_idx),
    .rest      (rest_mask),
    .final_one (cur_final)
  );

  assign sp_misaligned = sp_in[ALIGN_BITS-1:0] != '0;
  assign mem_req  = state_q == PS_LOAD;
  assign mem_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= PS_IDLE;
      mask_q        <= '0;
      addr_q        <= '0;
      rf_we         <= 1'b0;
      rf_idx        <= '0;
      rf_data       <= '0;
      branch_valid  <= 1'b0;
      branch_target <= '0;
      isa_sel       <= 1'b0;
      done          <= 1'b0;
      new_sp        <= '0;
      illegal       <= 1'b0;
      align_fault   <= 1'b0;
    end else begin
      rf_we        <= 1'b0;
      branch_valid <= 1'b0;
      done         <= 1'b0;
      illegal      <= 1'b0;
      align_fault  <= 1'b0;
      unique case (state_q)
        PS_IDLE: begin
          if (start) begin
            if (dec_bad || sp_misaligned) begin
              done        <= 1'b1;
              illegal     <= dec_bad;
              align_fault <= !dec_bad;
              new_sp      <= sp_in;
            end else begin
              mask_q  <= dec_mask;
              addr_q  <= sp_in;
              state_q <= PS_LOAD;
            end
          end
        end
        PS_LOAD: begin
          if (mem_valid) begin
            if (cur_idx == IDX_W'(PC_IDX)) begin
              branch_valid  <= 1'b1;
              branch_target <= {mem_rdata[ADDR_W-1:1], 1'b0};
              isa_sel       <= mem_rdata[0];
            end else begin
              rf_we   <= 1'b1;
              rf_idx  <= cur_idx;
              rf_data <= mem_rdata;
            end
            mask_q <= rest_mask;
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            if (cur_final) state_q <= PS_FIN;
          end
        end
        PS_FIN: begin
          done    <= 1'b1;
          new_sp  <= addr_q;
          state_q <= PS_IDLE;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R8
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[ALIGN_BITS-1:0] == '0); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_BRANCH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |=> done); // R3
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || align_fault) |-> !rf_we && !branch_valid && !mem_req); // R5
  AST_WE_LOW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_idx < 4'(GPR_N)); // R1
endmodule

// File: tb/stack_pop_sequencer_tb.sv
module stack_pop_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        in_cond_block = 1'b0;
  logic        last_in_block = 1'b0;
  logic [31:0] sp_in = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        mem_valid;
  logic        rf_we;
  logic [3:0]  rf_idx;
  logic [31:0] rf_data;
  logic        branch_valid;
  logic [31:0] branch_target;
  logic        isa_sel;
  logic        done;
  logic [31:0] new_sp;
  logic        illegal;
  logic        align_fault;

  int compared = 0;
  int mismatched = 0;
  int lat = 0;
  int wc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stack_pop_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .in_cond_block(in_cond_block), .last_in_block(last_in_block), .sp_in(sp_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .branch_valid(branch_valid), .branch_target(branch_target), .isa_sel(isa_sel),
    .done(done), .new_sp(new_sp), .illegal(illegal), .align_fault(align_fault)
  );

  function automatic logic [31:0] word_at(logic [31:0] a);
    return {a[7:0], a[15:8], ~a[7:0], a[9:2]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
      wc <= 0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0;
      wc <= 0;
    end else if (mem_req) begin
      if (wc >= lat) begin
        mem_valid <= 1'b1;
        mem_rdata <= word_at(mem_addr);
        wc <= 0;
      end else wc <= wc + 1;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] ins;
    logic [31:0] sp;
    logic        incb;
    logic        lastb;
    logic        e_ill;
    logic        e_al;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'hBC01, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 single
    '{16'hBCFF, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 all low
    '{16'hBD00, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 pc only
    '{16'hBDFF, 32'h0000_4000, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 all
    '{16'hBC00, 32'h0000_5000, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 empty
    '{16'hBD05, 32'h0000_6000, 1'b1, 1'b0, 1'b1, 1'b0},  // R6 misplaced pc
    '{16'hBD05, 32'h0000_6100, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 last in block
    '{16'hBC0F, 32'h0000_1002, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 misaligned
    '{16'hAC0F, 32'h0000_7000, 1'b0, 1'b0, 1'b1, 1'b0},  // R1 wrong opcode
    '{16'hBC81, 32'hFFFF_FFF8, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 wrap
    '{16'hBD05, 32'h0000_6001, 1'b1, 1'b0, 1'b1, 1'b0}   // R6 beats R7
  };

  task automatic run_op(logic [15:0] ins, logic [31:0] sp, logic incb, logic lastb,
                        logic e_ill, logic e_al, bit poke);
    logic [15:0] m;
    int nload;
    int k = 0;
    int nxt = 0;
    int cyc = 0;
    bit prev_evt = 1'b0;
    bit saw_req = 1'b0;
    bit ok;
    m = {ins[8], 7'b0, ins[7:0]};
    nload = $countones(m);
    @(negedge clk);
    instr = ins; sp_in = sp; in_cond_block = incb; last_in_block = lastb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 400) begin
      if (mem_req) saw_req = 1'b1;
      if (rf_we) begin
        while (nxt < 16 && !m[nxt]) nxt++;
        check(rf_idx == 4'(nxt) && nxt < 8, "R2 idx", 32'(rf_idx), 32'(nxt));
        check(rf_data == word_at(sp + 32'(4*k)), "R2 data", rf_data, word_at(sp + 32'(4*k)));
        nxt++; k++;
      end
      if (branch_valid) begin
        logic [31:0] w;
        w = word_at(sp + 32'(4*k));
        check(m[15] && k == nload - 1, "R3 pc last", 32'(k), 32'(nload - 1));
        check(branch_target == {w[31:1], 1'b0} && isa_sel == w[0], "R3 target",
              branch_target, {w[31:1], 1'b0});
        k++;
      end
      prev_evt = rf_we || branch_valid;
      if (poke && cyc == 2) begin
        instr = 16'hBC01; sp_in = 32'h0000_9000; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done == 1'b1, "R4 done seen", 32'(done), 32'd1);
    check(illegal == e_ill, "R1/R5/R6 illegal", 32'(illegal), 32'(e_ill));
    check(align_fault == e_al, "R7 align_fault", 32'(align_fault), 32'(e_al));
    if (e_ill || e_al) begin
      check(cyc == 0 && !saw_req && k == 0, "R5/R7 no loads", 32'(k), 32'd0);
      check(new_sp == sp, "R5/R7 sp kept", new_sp, sp);
    end else begin
      check(k == nload, "R2 load count", 32'(k), 32'(nload));
      check(prev_evt, "R4 done after final write", 32'(prev_evt), 32'd1);
      check(new_sp == sp + 32'(4*nload), "R4 new_sp", new_sp, sp + 32'(4*nload));
    end
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !rf_we && !mem_req && !branch_valid && !illegal && !align_fault,
          "reset quiet", {27'd0, done, rf_we, mem_req, branch_valid, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      run_op(VECS[i].ins, VECS[i].sp, VECS[i].incb, VECS[i].lastb,
             VECS[i].e_ill, VECS[i].e_al, 1'b0);
    // R2 R3 R4 R5: every mask value, immediate memory
    for (int mv = 0; mv < 512; mv++)
      run_op({7'b1011110, 9'(mv)}, 32'h0001_0000 + 32'(mv*64), 1'b0, 1'b0, mv == 0, 1'b0, 1'b0);
    // R8: stalled memory
    lat = 2;
    for (int mv = 0; mv < 512; mv += 37)
      run_op({7'b1011110, 9'(mv)}, 32'h0002_0000 + 32'(mv*64), 1'b0, 1'b0, mv == 0, 1'b0, 1'b0);
    run_op(16'hBDFF, 32'h0003_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: start while busy is ignored
    lat = 1;
    run_op(16'hBCFF, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R1: non-matching opcode with pc bit
    lat = 0;
    run_op(16'hBF01, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule